// File: doc/BRIEF.md
# Three-Level Wavelet Decomposition Sequencer

This block runs a fixed three-level two-dimensional wavelet split on a square image. It uses one shared transform stage for every level. Level 1 takes its samples from an external stream, two samples per clock. Each level's low-low result is parked in an on-chip store that holds a quarter of the image. The next level then reads that result back through an input selector, two words per clock. An address sequencer keeps the level counter and the block position, and it produces the read and write addresses of the store.

Every level delivers its three detail bands on a two-lane output. The last level also delivers its low-low band. Each lane carries a level tag and a band code. Because the schedule is fixed by the sample rate, an 8×8 image streamed without gaps behaves as follows:
- level 1 consumes cycles 0–31;
- level 2 consumes cycles 32–39;
- level 3 consumes cycles 40–41.

A one-cycle completion pulse follows the final coefficient.

The stream order is block-major. Each 2×2 block arrives as two beats:
- the top pair (row 2r, columns 2c and 2c+1);
- then the bottom pair (row 2r+1, the same columns).

Blocks advance in raster order.

Top module: `dwt_ml_ctrl`

## Requirements
- R1: After reset, `out_vld` is 00 and `done` is 0 until the first output beat.
- R2: For a block with top pair (a,b) and bottom pair (c,d), the block produces four values. LL = a+b+c+d, LH = a−b+c−d, HL = a+b−c−d and HH = a−b−c+d. These use signed inputs that are sign-extended to CW = DW+2·LEVELS bits.
- R3: The block emits two output beats. Beat A comes two cycles after the cycle that delivers the block's bottom pair; beat B follows on the next cycle.
  - Beat A: lane 0 holds LH (band code 1) and lane 1 holds HL (band code 2), so `out_vld`=11.
  - Beat B: lane 0 holds HH (band code 3). Band code 0 means LL.
- R4: At every level above 1, the block's input is the previous level's LL array, read in the same block-major order. The level tag of every beat equals the level that produced it, counting from 1.
- R5: At the final level, beat B also carries LL on lane 1, so `out_vld`=11. At the other levels, lane 1 of beat B is idle and `out_vld`=01.
- R6: For N=8 with no input gaps, the work takes 42 input cycles. `done` rises 45 cycles after the first level-1 beat.
- R7: `in_valid` and the input data have no effect while level 2 or level 3 is running.
- R8: Low cycles of `in_valid` during level 1 pause the sequencer and leave every coefficient unchanged.
- R9: `done` is high for exactly one cycle, in the cycle right after beat B of the final block of the final level.
- R10: A new image may start in the cycle after the final level's last input beat. Both images then produce correct results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Level-1 sample pair present |
| in_d0 | input | DW | Left sample of the pair, signed |
| in_d1 | input | DW | Right sample of the pair, signed |
| out_vld | output | 2 | Lane valid bits, one per lane |
| out_lvl | output | LW | Level tag of the beat (1..LEVELS) |
| out_band0 | output | 2 | Band code of lane 0 |
| out_band1 | output | 2 | Band code of lane 1 |
| out_c0 | output | CW | Lane 0 coefficient, signed |
| out_c1 | output | CW | Lane 1 coefficient, signed |
| done | output | 1 | One-cycle pulse when an image is complete |

## Verification
The checker assumes two things:
- `rst` is not raised in the middle of an image;
- the source gives up on level-1 pairs only through low `in_valid` cycles, never by dropping a beat.

Its properties track the pairing of beat A and beat B, where the final level's LL lane may appear, and the shape of the completion pulse. The stimulus keeps to these limits. It counts accepted level-1 beats, so it knows exactly when levels 2 and 3 run. It fills only those cycles with junk `in_valid` traffic. It restarts the next image no earlier than the cycle after the final level ends. It also uses sample values at both ends of the DW range, so the CW-bit results are exercised at their extremes.

// File: rtl/dwt_ml_pkg.sv
package dwt_ml_pkg;
   // band codes on the output lanes
   typedef enum logic [1:0] {
      BAND_LL = 2'd0,
      BAND_LH = 2'd1,
      BAND_HL = 2'd2,
      BAND_HH = 2'd3
   } band_e;
endpackage

// File: rtl/dwt_ml_seq.sv
// Address sequencer: level counter, block position, store addresses.
module dwt_ml_seq #(
   parameter int N      = 8,
   parameter int LEVELS = 3,
   localparam int LOG2N = $clog2(N),
   localparam int AW    = 2 * LOG2N - 2,
   localparam int LW    = $clog2(LEVELS + 1),
   localparam int RW    = LOG2N - 1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          in_valid,
   output logic          go,
   output logic          ph,
   output logic          from_ram,
   output logic [AW-1:0] rd_addr,
   output logic [LW-1:0] lvl,
   output logic [AW-1:0] widx,
   output logic          last_blk
);
   logic [LW-1:0] lvl_q;
   logic [RW-1:0] r_q, c_q;
   logic          ph_q;
   logic          c_end, r_end;
   int            sh;

   always_comb begin
      sh       = LOG2N - int'(lvl_q);          // log2 of blocks per row
      c_end    = (int'(c_q) == (1 << sh) - 1);
      r_end    = (int'(r_q) == (1 << sh) - 1);
      go       = (lvl_q == LW'(1)) ? in_valid : 1'b1;
      from_ram = (lvl_q != LW'(1));
      rd_addr  = AW'(((2 * int'(r_q) + int'(ph_q)) << (sh + 1)) + 2 * int'(c_q));
      widx     = AW'((int'(r_q) << sh) + int'(c_q));
      last_blk = c_end && r_end;
      ph       = ph_q;
      lvl      = lvl_q;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         lvl_q <= LW'(1);
         r_q   <= '0;
         c_q   <= '0;
         ph_q  <= 1'b0;
      end else if (go) begin
         if (!ph_q) begin
            ph_q <= 1'b1;
         end else begin
            ph_q <= 1'b0;
            if (!c_end) begin
               c_q <= c_q + 1'b1;
            end else begin
               c_q <= '0;
               if (!r_end) begin
                  r_q <= r_q + 1'b1;
               end else begin
                  r_q   <= '0;
                  lvl_q <= (lvl_q == LW'(LEVELS)) ? LW'(1) : lvl_q + 1'b1;
               end
            end
         end
      end
   end
endmodule

// File: rtl/dwt_ml_ram.sv
// Quarter-image store: one write port, an even/odd read pair.
module dwt_ml_ram #(
   parameter int AW = 4,
   parameter int CW = 14,
   localparam int DEPTH = 1 << AW
) (
   input  logic                clk,
   input  logic                we,
   input  logic [AW-1:0]       waddr,
   input  logic [CW-1:0]       wdata,
   input  logic [AW-1:0]       raddr,
   output logic [1:0][CW-1:0]  rdata
);
   logic [CW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   for (genvar gi = 0; gi < 2; gi++) begin : g_rd
      assign rdata[gi] = mem[{raddr[AW-1:1], 1'(gi)}];
   end
endmodule

// File: rtl/dwt_ml_xform.sv
// Shared 2x2 transform stage: holds the top pair, finishes on the bottom pair.
module dwt_ml_xform #(
   parameter int CW = 14,
   parameter int LW = 2,
   parameter int AW = 4
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          go,
   input  logic          ph,
   input  logic [CW-1:0] s0,
   input  logic [CW-1:0] s1,
   input  logic [LW-1:0] t_lvl,
   input  logic [AW-1:0] t_widx,
   input  logic          t_last,
   output logic          vld,
   output logic [CW-1:0] ll,
   output logic [CW-1:0] lh,
   output logic [CW-1:0] hl,
   output logic [CW-1:0] hh,
   output logic [LW-1:0] o_lvl,
   output logic [AW-1:0] o_widx,
   output logic          o_last
);
   logic signed [CW-1:0] a_q, b_q, cs, ds;

   assign cs = $signed(s0);
   assign ds = $signed(s1);

   always_ff @(posedge clk) begin
      if (rst) begin
         vld    <= 1'b0;
         a_q    <= '0;
         b_q    <= '0;
         ll     <= '0;
         lh     <= '0;
         hl     <= '0;
         hh     <= '0;
         o_lvl  <= '0;
         o_widx <= '0;
         o_last <= 1'b0;
      end else begin
         vld <= go && ph;
         if (go && !ph) begin
            a_q <= cs;
            b_q <= ds;
         end
         if (go && ph) begin
            ll     <= a_q + b_q + cs + ds;
            lh     <= a_q - b_q + cs - ds;
            hl     <= a_q + b_q - cs - ds;
            hh     <= a_q - b_q - cs + ds;
            o_lvl  <= t_lvl;
            o_widx <= t_widx;
            o_last <= t_last;
         end
      end
   end
endmodule

// File: rtl/dwt_ml_ctrl.sv
module dwt_ml_ctrl
   import dwt_ml_pkg::*;
#(
   parameter int N      = 8,
   parameter int LEVELS = 3,
   parameter int DW     = 8,
   localparam int LW    = $clog2(LEVELS + 1),
   localparam int CW    = DW + 2 * LEVELS,
   localparam int AW    = 2 * $clog2(N) - 2
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          in_valid,
   input  logic [DW-1:0] in_d0,
   input  logic [DW-1:0] in_d1,
   output logic [1:0]    out_vld,
   output logic [LW-1:0] out_lvl,
   output logic [1:0]    out_band0,
   output logic [1:0]    out_band1,
   output logic [CW-1:0] out_c0,
   output logic [CW-1:0] out_c1,
   output logic          done
);
   if (LEVELS < 1 || N < 4 || N < (1 << LEVELS) || (N & (N - 1)) != 0) begin : g_bad_cfg
      $error("dwt_ml_ctrl: N must be a power of two, at least 4 and at least 2**LEVELS");
   end
   if (DW < 2) begin : g_bad_dw
      $error("dwt_ml_ctrl: DW must be at least 2");
   end

   logic          go, ph, from_ram, last_blk;
   logic [AW-1:0] rd_addr, widx;
   logic [LW-1:0] lvl;

   dwt_ml_seq #(.N(N), .LEVELS(LEVELS)) seq_i (
      .clk(clk), .rst(rst), .in_valid(in_valid), .go(go), .ph(ph),
      .from_ram(from_ram), .rd_addr(rd_addr), .lvl(lvl), .widx(widx),
      .last_blk(last_blk)
   );

   logic [1:0][DW-1:0] ext;
   logic [1:0][CW-1:0] ram_rd, xin;
   logic               xf_vld, xf_last, ram_we;
   logic [CW-1:0]      xf_ll, xf_lh, xf_hl, xf_hh;
   logic [LW-1:0]      xf_lvl;
   logic [AW-1:0]      xf_widx;

   assign ext = {in_d1, in_d0};

   // input selector: external stream at level 1, stored LL afterwards
   for (genvar gi = 0; gi < 2; gi++) begin : g_sel
      assign xin[gi] = from_ram ? ram_rd[gi]
                                : {{(CW - DW){ext[gi][DW-1]}}, ext[gi]};
   end

   dwt_ml_xform #(.CW(CW), .LW(LW), .AW(AW)) xf_i (
      .clk(clk), .rst(rst), .go(go), .ph(ph), .s0(xin[0]), .s1(xin[1]),
      .t_lvl(lvl), .t_widx(widx), .t_last(last_blk),
      .vld(xf_vld), .ll(xf_ll), .lh(xf_lh), .hl(xf_hl), .hh(xf_hh),
      .o_lvl(xf_lvl), .o_widx(xf_widx), .o_last(xf_last)
   );

   assign ram_we = xf_vld && (xf_lvl != LW'(LEVELS));

   dwt_ml_ram #(.AW(AW), .CW(CW)) ram_i (
      .clk(clk), .we(ram_we), .waddr(xf_widx), .wdata(xf_ll),
      .raddr(rd_addr), .rdata(ram_rd)
   );

   // two-beat output serializer
   logic          pend_q, pend_fin_q, pend_last_q, done_arm_q;
   logic [CW-1:0] hold_hh_q, hold_ll_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         out_vld     <= 2'b00;
         out_lvl     <= '0;
         out_band0   <= BAND_LL;
         out_band1   <= BAND_LL;
         out_c0      <= '0;
         out_c1      <= '0;
         done        <= 1'b0;
         pend_q      <= 1'b0;
         pend_fin_q  <= 1'b0;
         pend_last_q <= 1'b0;
         done_arm_q  <= 1'b0;
         hold_hh_q   <= '0;
         hold_ll_q   <= '0;
      end else begin
         done       <= done_arm_q;
         done_arm_q <= pend_q && pend_fin_q && pend_last_q;
         if (xf_vld) begin
            out_vld     <= 2'b11;
            out_lvl     <= xf_lvl;
            out_band0   <= BAND_LH;
            out_band1   <= BAND_HL;
            out_c0      <= xf_lh;
            out_c1      <= xf_hl;
            hold_hh_q   <= xf_hh;
            hold_ll_q   <= xf_ll;
            pend_fin_q  <= (xf_lvl == LW'(LEVELS));
            pend_last_q <= xf_last;
            pend_q      <= 1'b1;
         end else if (pend_q) begin
            out_vld   <= {pend_fin_q, 1'b1};
            out_band0 <= BAND_HH;
            out_band1 <= BAND_LL;
            out_c0    <= hold_hh_q;
            out_c1    <= hold_ll_q;
            pend_q    <= 1'b0;
         end else begin
            out_vld <= 2'b00;
         end
      end
   end
endmodule

// File: rtl/dwt_ml_ctrl_chk.sv
module dwt_ml_ctrl_chk #(
   parameter int LEVELS = 3,
   parameter int LW     = 2
) (
   input logic          clk,
   input logic          rst,
   input logic [1:0]    out_vld,
   input logic [LW-1:0] out_lvl,
   input logic [1:0]    out_band0,
   input logic [1:0]    out_band1,
   input logic          done
);
   // R4: every beat is tagged with a real level
   assert_lvl_range_R4: assert property (@(posedge clk) disable iff (rst)
      (out_vld != 2'b00) |-> (out_lvl >= LW'(1) && out_lvl <= LW'(LEVELS)));

   // R3: beat A is always followed by beat B of the same level
   assert_beat_pair_R3: assert property (@(posedge clk) disable iff (rst)
      (out_vld[0] && out_band0 == 2'd1)
      |=> (out_vld[0] && out_band0 == 2'd3 && $stable(out_lvl)));

   // R5: an LL lane only appears at the final level, and lane 1 never alone
   assert_ll_final_R5: assert property (@(posedge clk) disable iff (rst)
      (out_vld[1] && out_band1 == 2'd0) |-> (out_lvl == LW'(LEVELS)));
   assert_lane_order_R5: assert property (@(posedge clk) disable iff (rst)
      out_vld[1] |-> out_vld[0]);

   // R9: completion follows a final-level beat B and lasts one cycle
   assert_done_after_b_R9: assert property (@(posedge clk) disable iff (rst)
      done |-> $past(out_vld[0] && out_band0 == 2'd3 && out_lvl == LW'(LEVELS)));
   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);
endmodule

bind dwt_ml_ctrl dwt_ml_ctrl_chk #(.LEVELS(LEVELS), .LW(LW)) chk_i (
   .clk(clk), .rst(rst), .out_vld(out_vld), .out_lvl(out_lvl),
   .out_band0(out_band0), .out_band1(out_band1), .done(done)
);

// File: tb/dwt_ml_ctrl_tb.sv
`timescale 1ns/1ps
module dwt_ml_ctrl_tb_top;
   localparam int N  = 8;
   localparam int L  = 3;
   localparam int DW = 8;
   localparam int LW = 2;
   localparam int CW = DW + 2 * L;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          in_valid = 1'b0;
   logic [DW-1:0] in_d0 = '0, in_d1 = '0;
   logic [1:0]    out_vld;
   logic [LW-1:0] out_lvl;
   logic [1:0]    out_band0, out_band1;
   logic [CW-1:0] out_c0, out_c1;
   logic          done;

   always #5 clk = ~clk;

   dwt_ml_ctrl #(.N(N), .LEVELS(L), .DW(DW)) dut_i (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_d0(in_d0), .in_d1(in_d1),
      .out_vld(out_vld), .out_lvl(out_lvl), .out_band0(out_band0),
      .out_band1(out_band1), .out_c0(out_c0), .out_c1(out_c1), .done(done)
   );

   int n_chk = 0, n_fail = 0;
   int cyc = 0;
   int last_done_cyc = -1;
   int done_count = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s at cycle %0d: actual=%0d expected=%0d",
                  req, what, cyc, act, exp);
      end
   endtask

   // expected output trace, keyed by cycle
   logic [1:0] e_vld [int];
   int e_lvl [int], e_b0 [int], e_b1 [int], e_c0 [int], e_c1 [int];
   bit e_done [int];

   // behavioural reference state
   int m_lvl = 1, m_blk = 0, m_ph = 0, ha = 0, hb = 0;
   int ll_prev [N/2][N/2];
   int ll_cur  [N/2][N/2];

   always @(negedge clk) begin
      if (!rst) begin
         logic [1:0] ev;
         bit ed;
         int w, bk, r, c, v0, v1, sll, slh, shl, shh;
         string creq;
         ev = e_vld.exists(cyc) ? e_vld[cyc] : 2'b00;
         ed = e_done.exists(cyc);
         if (ev != 2'b00 || out_vld != 2'b00)
            chk(out_vld == ev, "R3", "lane valid", int'(out_vld), int'(ev));
         if (ev[0] && out_vld[0]) begin
            creq = (e_lvl[cyc] == 1) ? "R2" : "R4";
            chk(int'(out_lvl) == e_lvl[cyc], "R4", "level tag", int'(out_lvl), e_lvl[cyc]);
            chk(int'(out_band0) == e_b0[cyc], "R3", "lane0 band", int'(out_band0), e_b0[cyc]);
            chk(int'($signed(out_c0)) == e_c0[cyc], creq, "lane0 coef", int'($signed(out_c0)), e_c0[cyc]);
         end
         if (ev[1] && out_vld[1]) begin
            creq = (e_b1[cyc] == 0) ? "R5" : ((e_lvl[cyc] == 1) ? "R2" : "R4");
            chk(int'(out_band1) == e_b1[cyc], "R3", "lane1 band", int'(out_band1), e_b1[cyc]);
            chk(int'($signed(out_c1)) == e_c1[cyc], creq, "lane1 coef", int'($signed(out_c1)), e_c1[cyc]);
         end
         if (ed || done) chk(done == ed, "R9", "done pulse", int'(done), int'(ed));
         if (done) begin
            last_done_cyc = cyc;
            done_count++;
         end

         // reference model: is a beat taken in this cycle?
         if (m_lvl != 1 || in_valid) begin
            w  = N >> (m_lvl - 1);
            bk = w / 2;
            r  = m_blk / bk;
            c  = m_blk % bk;
            if (m_lvl == 1) begin
               v0 = int'($signed(in_d0));
               v1 = int'($signed(in_d1));
            end else begin
               v0 = ll_prev[2*r + m_ph][2*c];
               v1 = ll_prev[2*r + m_ph][2*c + 1];
            end
            if (m_ph == 0) begin
               ha = v0; hb = v1; m_ph = 1;
            end else begin
               sll = ha + hb + v0 + v1;
               slh = ha - hb + v0 - v1;
               shl = ha + hb - v0 - v1;
               shh = ha - hb - v0 + v1;
               e_vld[cyc+2] = 2'b11; e_lvl[cyc+2] = m_lvl;
               e_b0[cyc+2] = 1; e_c0[cyc+2] = slh;
               e_b1[cyc+2] = 2; e_c1[cyc+2] = shl;
               e_vld[cyc+3] = (m_lvl == L) ? 2'b11 : 2'b01; e_lvl[cyc+3] = m_lvl;
               e_b0[cyc+3] = 3; e_c0[cyc+3] = shh;
               e_b1[cyc+3] = 0; e_c1[cyc+3] = sll;
               if (m_lvl < L) ll_cur[r][c] = sll;
               m_ph = 0;
               if (m_blk == bk * bk - 1) begin
                  m_blk = 0;
                  if (m_lvl == L) begin
                     e_done[cyc+4] = 1'b1;
                     m_lvl = 1;
                  end else begin
                     ll_prev = ll_cur;
                     m_lvl++;
                  end
               end else begin
                  m_blk++;
               end
            end
         end
      end
   end

   function automatic int pix(input int id, input int i, input int j);
      if (id == 9) return -128;
      if (id == 8) return 127;
      return ((i * 13 + j * 7 + id * 29 + i * j) % 256) - 128;
   endfunction

   task automatic step;
      @(posedge clk);
      #1;
   endtask

   // streams one image in block-major order; gaps insert an idle cycle per beat
   task automatic send_image(input int id, input bit gaps, output int first_cyc);
      first_cyc = -1;
      for (int b = 0; b < (N/2) * (N/2); b++) begin
         for (int p = 0; p < 2; p++) begin
            if (gaps) begin
               in_valid = 1'b0;
               in_d0 = DW'(b * 5 + 3);
               step();
            end
            in_valid = 1'b1;
            in_d0 = DW'(pix(id, 2 * (b / (N/2)) + p, 2 * (b % (N/2))));
            in_d1 = DW'(pix(id, 2 * (b / (N/2)) + p, 2 * (b % (N/2)) + 1));
            if (first_cyc < 0) first_cyc = cyc;
            step();
         end
      end
      in_valid = 1'b0;
   endtask

   task automatic idle(input int n);
      in_valid = 1'b0;
      repeat (n) step();
   endtask

   bit finished = 1'b0;

   initial begin
      int t0, f0, d0;
      rst = 1'b1;
      repeat (3) @(posedge clk);
      #1;
      rst = 1'b0;
      @(negedge clk);
      chk(out_vld == 2'b00, "R1", "out_vld after reset", int'(out_vld), 0);
      chk(done == 1'b0, "R1", "done after reset", int'(done), 0);
      step();

      // S1: continuous image, fixed schedule
      f0 = n_fail;
      send_image(0, 1'b0, t0);
      idle(16);
      chk(last_done_cyc == t0 + 45, "R6", "done cycle vs first beat",
          last_done_cyc - t0, 45);
      chk(n_fail == f0, "R2", "level-1 image result mismatches", n_fail - f0, 0);

      // S2: gapped level-1 stream, then junk traffic during levels 2 and 3
      f0 = n_fail;
      send_image(1, 1'b1, t0);
      for (int k = 0; k < 10; k++) begin
         in_valid = 1'b1;
         in_d0 = DW'(k * 37 + 11);
         in_d1 = DW'(k * 91 + 5);
         step();
      end
      idle(16);
      chk(n_fail == f0, "R8", "gapped image mismatches", n_fail - f0, 0);
      chk(n_fail == f0, "R7", "junk input during levels 2-3 mismatches", n_fail - f0, 0);

      // S3: back-to-back images, second starts right after level 3
      f0 = n_fail;
      d0 = done_count;
      send_image(2, 1'b0, t0);
      idle(10);
      send_image(3, 1'b0, t0);
      idle(16);
      chk(done_count - d0 == 2, "R10", "completions for back-to-back pair",
          done_count - d0, 2);
      chk(n_fail == f0, "R10", "back-to-back mismatches", n_fail - f0, 0);

      // S4: range extremes
      f0 = n_fail;
      send_image(9, 1'b0, t0);
      idle(10);
      send_image(8, 1'b0, t0);
      idle(16);
      chk(n_fail == f0, "R5", "extreme-value image mismatches", n_fail - f0, 0);
      chk(n_fail == f0, "R4", "fed-back level mismatches", n_fail - f0, 0);

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL R6 watchdog expired: actual=running expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end
endmodule